// File: doc/BRIEF.md
# IDE Channel I/O Address Decoder

This block sits on the host I/O path of a two-channel IDE controller. It compares each I/O read or write against the command window and the control window of both channels. It then raises a single-cycle select toward the register that the access addresses. That register is one of the eight task-file registers, the 16/32-bit data port, or the device-control / alternate-status register. Accesses that fall inside a window but have an illegal size or offset are claimed and then neutralised. A rejected read floats to all-ones at the access width, and a rejected write produces no select.

The port map comes from the low nibble of a programming-interface byte. The value 0xA places both channels at the fixed compatibility ports. The value 0xF places both channels at relocatable native bases, which are supplied as inputs by the base-address logic outside this block. Any other nibble leaves the map as it is. The interrupt-pin value shown on `int_pin` follows the map: 0 for fixed ports and 1 for native. Read data from the channels returns through the decoder. It is masked to the access width, in little-endian lane order.

Top module: `ide_io_decoder`

## Requirements
- R1: After reset the decoder is in native mode (`legacy_mode`=0, `int_pin`=1), and all selects, `acc_wr` and `rd_valid` are 0.
- R2: A `pif_we` cycle whose `pif_val[3:0]` is 0xA switches to fixed-port mode with `int_pin`=0. A value of 0xF switches to native mode with `int_pin`=1. Any other nibble leaves the mode and `int_pin` unchanged. The new mode applies from the next clock edge.
- R3: In fixed-port mode the primary command window is 0x1F0–0x1F7, the primary control register is 0x3F6, the secondary command window is 0x170–0x177 and the secondary control register is 0x376. The native windows are not decoded in this mode.
- R4: In native mode the command window is the 8 bytes at `nat_cmd_base_*` (low 3 bits ignored). The control window is the 4 bytes at `nat_ctl_base_*` (low 2 bits ignored), and its register sits at offset 2. The fixed ports are not decoded in this mode.
- R5: A 1-byte access (`io_size`=0) to command-window offset k sets bit k of that channel's `tf_sel_*` for exactly the one cycle after the strobe edge. In that cycle `acc_wr` gives the direction (1 = write) and `data_width`=0.
- R6: A 2-byte (`io_size`=1) or 4-byte (`io_size`=2) access at command offset 0 sets `tf_sel_*` bit 0, with `data_width` equal to 1 or 2 respectively.
- R7: A 2- or 4-byte command access at a nonzero offset produces no select. A read of this kind gives `rd_valid` with `rd_data` 0x0000FFFF or 0xFFFFFFFF, and a write leaves `acc_wr` at 0.
- R8: On the control window only a 1-byte access at offset 2 pulses `ctl_sel_*`. A write here is a device-control write and a read is an alternate-status read. Any other control access produces no select, and a read of this kind returns all-ones at its width (0xFF for a byte).
- R9: A claimed read returns `rd_valid` for one cycle, with `rd_data` equal to the channel's read data masked to the access width. Outside `rd_valid`, `rd_data` is 0. On an accepted write, `acc_wdata` carries `io_wdata` masked to the access width.
- R10: An access is taken only when exactly one of `io_rd` and `io_wr` is high and `io_size` is not 3. Accesses with both strobes high, a size code of 3, or an address outside every window produce no select and no `rd_valid`.
- R11: When a primary and a secondary window both match an address, the primary channel takes the access.
- R12: At most one select (`tf_sel_p`, `tf_sel_s`, `ctl_sel_p`, `ctl_sel_s` bits combined) is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pif_we | input | 1 | Programming-interface byte write strobe |
| pif_val | input | 8 | Programming-interface byte |
| nat_cmd_base_p | input | 16 | Primary native command window base |
| nat_ctl_base_p | input | 16 | Primary native control window base |
| nat_cmd_base_s | input | 16 | Secondary native command window base |
| nat_ctl_base_s | input | 16 | Secondary native control window base |
| io_addr | input | 16 | I/O address |
| io_size | input | 2 | Access size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = none |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 32 | Write data, little-endian |
| chan_rdata_p | input | 32 | Read data from the primary channel registers |
| chan_rdata_s | input | 32 | Read data from the secondary channel registers |
| legacy_mode | output | 1 | 1 when the fixed-port map is active |
| int_pin | output | 8 | Interrupt-pin value: 0 for fixed ports, 1 for native |
| tf_sel_p | output | 8 | Primary task-file register select, one-hot pulse |
| tf_sel_s | output | 8 | Secondary task-file register select, one-hot pulse |
| ctl_sel_p | output | 1 | Primary device-control / alternate-status select pulse |
| ctl_sel_s | output | 1 | Secondary device-control / alternate-status select pulse |
| acc_wr | output | 1 | Direction of the current select (1 = write) |
| data_width | output | 2 | Data-port width of the current select: 0 = 8, 1 = 16, 2 = 32 bits |
| acc_wdata | output | 32 | Write data of the last accepted write, masked to width |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 32 | Read return data |

## Verification
Some properties are checked on every cycle. At most one select is high at a time. Every select or read return traces back to a single-strobe cycle. A select with a wide data-port width is always register 0. A read with no select carries an all-ones pattern of a legal width. The mode and interrupt-pin value change only on a 0xA or 0xF nibble. Other behaviour can only be shown by the directed scenarios: the exact address map in each mode, which register bit a given offset selects, the channel priority on overlapping bases, the masking of read and write data, and the rejection of misaligned wide accesses.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;

  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic {
    MODE_NATIVE = 1'b0,
    MODE_LEGACY = 1'b1
  } port_mode_e;

  // Byte lanes enabled by an access of the given size, little-endian.
  function automatic logic [DATA_W-1:0] width_mask(acc_size_e sz);
    logic [DATA_W-1:0] m;
    case (sz)
      SZ_BYTE: m = DATA_W'(32'h0000_00FF);
      SZ_HALF: m = DATA_W'(32'h0000_FFFF);
      SZ_WORD: m = DATA_W'(32'hFFFF_FFFF);
      default: m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/ide_win_match.sv
module ide_win_match #(
  parameter int ADDR_W  = 16,
  parameter int SPAN_LG = 3
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [ADDR_W-1:0]  base,
  input  logic               en,
  output logic               hit,
  output logic [SPAN_LG-1:0] off
);

  // Window is naturally aligned; base bits below the span are ignored.
  always_comb begin
    hit = en && (addr[ADDR_W-1:SPAN_LG] == base[ADDR_W-1:SPAN_LG]);
    off = addr[SPAN_LG-1:0];
  end

endmodule

// File: rtl/ide_chan_decode.sv
module ide_chan_decode
  import ide_dec_pkg::*;
#(
  parameter int TF_REGS = 8,
  parameter int CMD_LG  = 3,
  parameter int CTL_LG  = 2,
  parameter int CTL_OFF = 2
) (
  input  logic              cmd_hit,
  input  logic              ctl_hit,
  input  logic [CMD_LG-1:0] cmd_off,
  input  logic [CTL_LG-1:0] ctl_off,
  input  acc_size_e         size,
  output logic [TF_REGS-1:0] tf_sel,
  output logic              ctl_sel,
  output logic              claim,
  output logic              reject,
  output logic              wide
);

  always_comb begin
    tf_sel  = '0;
    ctl_sel = 1'b0;
    claim   = 1'b0;
    reject  = 1'b0;
    wide    = 1'b0;
    if (cmd_hit) begin
      claim = 1'b1;
      if (size == SZ_BYTE) begin
        for (int i = 0; i < TF_REGS; i++) begin
          tf_sel[i] = (cmd_off == CMD_LG'(i));
        end
      end else if (cmd_off == '0) begin
        tf_sel[0] = 1'b1;
        wide      = 1'b1;
      end else begin
        reject = 1'b1;
      end
    end else if (ctl_hit) begin
      claim = 1'b1;
      if (size == SZ_BYTE && ctl_off == CTL_LG'(CTL_OFF)) begin
        ctl_sel = 1'b1;
      end else begin
        reject = 1'b1;
      end
    end
  end

endmodule

// File: rtl/ide_mode_ctl.sv
module ide_mode_ctl
  import ide_dec_pkg::*;
#(
  parameter logic [3:0] NIB_LEGACY = 4'hA,
  parameter logic [3:0] NIB_NATIVE = 4'hF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pif_we,
  input  logic [7:0] pif_val,
  output port_mode_e mode,
  output logic [7:0] int_pin
);

  port_mode_e mode_q, mode_d;
  logic       mode_en;

  always_comb begin
    mode_d  = mode_q;
    mode_en = 1'b0;
    if (pif_we) begin
      if (pif_val[3:0] == NIB_LEGACY) begin
        mode_d  = MODE_LEGACY;
        mode_en = 1'b1;
      end else if (pif_val[3:0] == NIB_NATIVE) begin
        mode_d  = MODE_NATIVE;
        mode_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_NATIVE;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  always_comb begin
    mode    = mode_q;
    int_pin = (mode_q == MODE_LEGACY) ? 8'd0 : 8'd1;
  end

endmodule

// File: rtl/ide_io_decoder.sv
module ide_io_decoder
  import ide_dec_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          TF_REGS     = 8,
  parameter int          CTL_SPAN    = 4,
  parameter int          CTL_OFF     = 2,
  parameter logic [15:0] LEG_CMD_P   = 16'h01F0,
  parameter logic [15:0] LEG_CTL_P   = 16'h03F4,
  parameter logic [15:0] LEG_CMD_S   = 16'h0170,
  parameter logic [15:0] LEG_CTL_S   = 16'h0374
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pif_we,
  input  logic [7:0]         pif_val,
  input  logic [ADDR_W-1:0]  nat_cmd_base_p,
  input  logic [ADDR_W-1:0]  nat_ctl_base_p,
  input  logic [ADDR_W-1:0]  nat_cmd_base_s,
  input  logic [ADDR_W-1:0]  nat_ctl_base_s,
  input  logic [ADDR_W-1:0]  io_addr,
  input  logic [1:0]         io_size,
  input  logic               io_rd,
  input  logic               io_wr,
  input  logic [31:0]        io_wdata,
  input  logic [31:0]        chan_rdata_p,
  input  logic [31:0]        chan_rdata_s,
  output logic               legacy_mode,
  output logic [7:0]         int_pin,
  output logic [TF_REGS-1:0] tf_sel_p,
  output logic [TF_REGS-1:0] tf_sel_s,
  output logic               ctl_sel_p,
  output logic               ctl_sel_s,
  output logic               acc_wr,
  output logic [1:0]         data_width,
  output logic [31:0]        acc_wdata,
  output logic               rd_valid,
  output logic [31:0]        rd_data
);

  localparam int NCH    = 2;
  localparam int CMD_LG = $clog2(TF_REGS);
  localparam int CTL_LG = $clog2(CTL_SPAN);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  // Mode register and interrupt-pin value.
  port_mode_e mode;

  ide_mode_ctl u_mode (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .pif_we  (pif_we),
    .pif_val (pif_val),
    .mode    (mode),
    .int_pin (int_pin)
  );

  assign legacy_mode = (mode == MODE_LEGACY);

  // Per-channel window bases: fixed ports or relocatable inputs.
  logic [ADDR_W-1:0] cmd_base [NCH];
  logic [ADDR_W-1:0] ctl_base [NCH];
  logic [ADDR_W-1:0] nat_cmd  [NCH];
  logic [ADDR_W-1:0] nat_ctl  [NCH];
  logic [ADDR_W-1:0] leg_cmd  [NCH];
  logic [ADDR_W-1:0] leg_ctl  [NCH];

  always_comb begin
    nat_cmd[0] = nat_cmd_base_p;
    nat_cmd[1] = nat_cmd_base_s;
    nat_ctl[0] = nat_ctl_base_p;
    nat_ctl[1] = nat_ctl_base_s;
    leg_cmd[0] = ADDR_W'(LEG_CMD_P);
    leg_cmd[1] = ADDR_W'(LEG_CMD_S);
    leg_ctl[0] = ADDR_W'(LEG_CTL_P);
    leg_ctl[1] = ADDR_W'(LEG_CTL_S);
  end

  acc_size_e          size_in;
  logic               acc_ok;
  logic [TF_REGS-1:0] tf_sel_c [NCH];
  logic [NCH-1:0]     ctl_sel_c;
  logic [NCH-1:0]     claim_c;
  logic [NCH-1:0]     reject_c;
  logic [NCH-1:0]     wide_c;

  assign size_in = acc_size_e'(io_size);
  assign acc_ok  = (io_rd ^ io_wr) && (size_in != SZ_RSVD);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic              cmd_hit;
    logic              ctl_hit;
    logic [CMD_LG-1:0] cmd_off;
    logic [CTL_LG-1:0] ctl_off;

    assign cmd_base[ch] = legacy_mode ? leg_cmd[ch] : nat_cmd[ch];
    assign ctl_base[ch] = legacy_mode ? leg_ctl[ch] : nat_ctl[ch];

    ide_win_match #(.ADDR_W(ADDR_W), .SPAN_LG(CMD_LG)) u_cmd_win (
      .addr (io_addr),
      .base (cmd_base[ch]),
      .en   (acc_ok),
      .hit  (cmd_hit),
      .off  (cmd_off)
    );

    ide_win_match #(.ADDR_W(ADDR_W), .SPAN_LG(CTL_LG)) u_ctl_win (
      .addr (io_addr),
      .base (ctl_base[ch]),
      .en   (acc_ok),
      .hit  (ctl_hit),
      .off  (ctl_off)
    );

    ide_chan_decode #(
      .TF_REGS (TF_REGS),
      .CMD_LG  (CMD_LG),
      .CTL_LG  (CTL_LG),
      .CTL_OFF (CTL_OFF)
    ) u_dec (
      .cmd_hit (cmd_hit),
      .ctl_hit (ctl_hit),
      .cmd_off (cmd_off),
      .ctl_off (ctl_off),
      .size    (size_in),
      .tf_sel  (tf_sel_c[ch]),
      .ctl_sel (ctl_sel_c[ch]),
      .claim   (claim_c[ch]),
      .reject  (reject_c[ch]),
      .wide    (wide_c[ch])
    );
  end

  // Channel arbitration: primary wins on overlapping windows.
  logic [NCH-1:0] won;
  logic           any_claim;
  logic           win_ch;
  logic           win_reject;
  logic           win_wide;

  always_comb begin
    won[0]     = claim_c[0];
    won[1]     = claim_c[1] && !claim_c[0];
    any_claim  = |claim_c;
    win_ch     = !claim_c[0];
    win_reject = won[0] ? reject_c[0] : reject_c[1];
    win_wide   = won[0] ? wide_c[0]   : wide_c[1];
  end

  // Next-state of the output stage.
  logic [TF_REGS-1:0] tf_sel_d [NCH];
  logic [NCH-1:0]     ctl_sel_d;
  logic               acc_wr_d;
  logic [1:0]         width_d;
  logic               rd_valid_d;
  logic               reject_d;
  logic               rd_ch_d;
  acc_size_e          rd_size_d;
  logic               wdata_en;
  logic [31:0]        wdata_d;

  always_comb begin
    for (int ch = 0; ch < NCH; ch++) begin
      tf_sel_d[ch]  = won[ch] ? tf_sel_c[ch]  : '0;
      ctl_sel_d[ch] = won[ch] ? ctl_sel_c[ch] : 1'b0;
    end
    acc_wr_d   = io_wr && any_claim && !win_reject;
    width_d    = (any_claim && win_wide) ? io_size : 2'd0;
    rd_valid_d = io_rd && any_claim;
    reject_d   = any_claim && win_reject;
    rd_ch_d    = win_ch;
    rd_size_d  = size_in;
    wdata_en   = acc_wr_d;
    wdata_d    = io_wdata & width_mask(size_in);
  end

  // Output stage registers.
  logic [TF_REGS-1:0] tf_sel_q [NCH];
  logic [NCH-1:0]     ctl_sel_q;
  logic               acc_wr_q;
  logic [1:0]         width_q;
  logic               rd_valid_q;
  logic               reject_q;
  logic               rd_ch_q;
  acc_size_e          rd_size_q;
  logic [31:0]        wdata_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      for (int ch = 0; ch < NCH; ch++) begin
        tf_sel_q[ch] <= '0;
      end
      ctl_sel_q  <= '0;
      acc_wr_q   <= 1'b0;
      width_q    <= 2'd0;
      rd_valid_q <= 1'b0;
      reject_q   <= 1'b0;
      rd_ch_q    <= 1'b0;
      rd_size_q  <= SZ_BYTE;
    end else begin
      for (int ch = 0; ch < NCH; ch++) begin
        tf_sel_q[ch] <= tf_sel_d[ch];
      end
      ctl_sel_q  <= ctl_sel_d;
      acc_wr_q   <= acc_wr_d;
      width_q    <= width_d;
      rd_valid_q <= rd_valid_d;
      reject_q   <= reject_d;
      rd_ch_q    <= rd_ch_d;
      rd_size_q  <= rd_size_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wdata_q <= '0;
    end else if (wdata_en) begin
      wdata_q <= wdata_d;
    end
  end

  // Read return path: channel data or floated all-ones, lane 0 aligned.
  logic [31:0] rd_mask;
  logic [31:0] rd_src;

  always_comb begin
    rd_mask = width_mask(rd_size_q);
    rd_src  = rd_ch_q ? chan_rdata_s : chan_rdata_p;
    if (!rd_valid_q) begin
      rd_data = '0;
    end else if (reject_q) begin
      rd_data = rd_mask;
    end else begin
      rd_data = rd_src & rd_mask;
    end
  end

  assign tf_sel_p   = tf_sel_q[0];
  assign tf_sel_s   = tf_sel_q[1];
  assign ctl_sel_p  = ctl_sel_q[0];
  assign ctl_sel_s  = ctl_sel_q[1];
  assign acc_wr     = acc_wr_q;
  assign data_width = width_q;
  assign acc_wdata  = wdata_q;
  assign rd_valid   = rd_valid_q;

endmodule

// File: rtl/ide_io_decoder_chk.sv
module ide_io_decoder_chk #(
  parameter int TF_REGS = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pif_we,
  input logic [7:0]         pif_val,
  input logic               io_rd,
  input logic               io_wr,
  input logic               legacy_mode,
  input logic [7:0]         int_pin,
  input logic [TF_REGS-1:0] tf_sel_p,
  input logic [TF_REGS-1:0] tf_sel_s,
  input logic               ctl_sel_p,
  input logic               ctl_sel_s,
  input logic [1:0]         data_width,
  input logic               rd_valid,
  input logic [31:0]        rd_data
);

  logic any_sel;
  assign any_sel = (|tf_sel_p) || (|tf_sel_s) || ctl_sel_p || ctl_sel_s;

  // R12: never more than one register selected
  a_r12_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tf_sel_p, tf_sel_s, ctl_sel_p, ctl_sel_s}));

  // R10: selects and read returns follow a single-strobe cycle
  a_r10_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (any_sel || rd_valid) |-> $past(io_rd ^ io_wr));

  // R2: nibble 0xA gives fixed ports with pin value 0
  a_r2_legacy_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (pif_we && pif_val[3:0] == 4'hA) |=> (legacy_mode && int_pin == 8'd0));

  // R2: nibble 0xF gives native map with pin value 1
  a_r2_native_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (pif_we && pif_val[3:0] == 4'hF) |=> (!legacy_mode && int_pin == 8'd1));

  // R2: any other cycle keeps the mode
  a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(pif_we && (pif_val[3:0] == 4'hA || pif_val[3:0] == 4'hF))
      |=> ($stable(legacy_mode) && $stable(int_pin)));

  // R6: wide data-port width only with task-file register 0
  a_r6_wide_offset0: assert property (@(posedge clk) disable iff (!rst_n)
    (data_width != 2'd0) |-> (tf_sel_p == TF_REGS'(1) || tf_sel_s == TF_REGS'(1)));

  // R7, R8: a read with no select floats to all-ones at a legal width
  a_r7_reject_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !any_sel) |->
      (rd_data == 32'h0000_00FF || rd_data == 32'h0000_FFFF || rd_data == 32'hFFFF_FFFF));

  // R9: read bus is quiet outside a read return
  a_r9_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data == 32'd0));

endmodule

bind ide_io_decoder ide_io_decoder_chk #(.TF_REGS(TF_REGS)) u_chk (.*);

// File: tb/ide_io_decoder_test.sv
`timescale 1ns/1ps
module ide_io_decoder_test;

  logic        clk;
  logic        rst_n;
  logic        pif_we;
  logic [7:0]  pif_val;
  logic [15:0] nat_cmd_base_p, nat_ctl_base_p, nat_cmd_base_s, nat_ctl_base_s;
  logic [15:0] io_addr;
  logic [1:0]  io_size;
  logic        io_rd, io_wr;
  logic [31:0] io_wdata;
  logic [31:0] chan_rdata_p, chan_rdata_s;
  logic        legacy_mode;
  logic [7:0]  int_pin;
  logic [7:0]  tf_sel_p, tf_sel_s;
  logic        ctl_sel_p, ctl_sel_s, acc_wr, rd_valid;
  logic [1:0]  data_width;
  logic [31:0] acc_wdata, rd_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  ide_io_decoder uut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Snapshot of outputs one cycle after the strobe edge
  logic [7:0]  s_tfp, s_tfs;
  logic        s_cp, s_cs, s_wr, s_rv;
  logic [1:0]  s_dw;
  logic [31:0] s_wd, s_rd;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(logic [15:0] a, logic [1:0] sz, logic rd, logic wr, logic [31:0] wd);
    @(negedge clk);
    io_addr = a; io_size = sz; io_rd = rd; io_wr = wr; io_wdata = wd;
    @(negedge clk);
    s_tfp = tf_sel_p; s_tfs = tf_sel_s; s_cp = ctl_sel_p; s_cs = ctl_sel_s;
    s_wr = acc_wr; s_rv = rd_valid; s_dw = data_width; s_wd = acc_wdata; s_rd = rd_data;
    io_rd = 1'b0; io_wr = 1'b0;
  endtask

  task automatic set_pif(logic [7:0] v);
    @(negedge clk);
    pif_we = 1'b1; pif_val = v;
    @(negedge clk);
    pif_we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 legacy_mode", legacy_mode, 0);
    chk("R1 int_pin", int_pin, 1);
    chk("R1 selects", {tf_sel_p, tf_sel_s, ctl_sel_p, ctl_sel_s}, 0);
    chk("R1 rd_valid/acc_wr", {rd_valid, acc_wr}, 0);
  endtask

  task automatic t_native_byte();
    access(16'hC003, 2'd0, 1, 0, 0);
    chk("R5 tf_sel_p", s_tfp, 8'h08);
    chk("R12 tf_sel_s", s_tfs, 0);
    chk("R4 R9 rd_valid", s_rv, 1);
    chk("R9 rd_data byte", s_rd, 32'h0000_00D4);
    chk("R5 dir/width", {s_wr, s_dw}, 0);
    access(16'hC017, 2'd0, 0, 1, 32'h1234_5699);
    chk("R5 tf_sel_s", s_tfs, 8'h80);
    chk("R5 acc_wr", s_wr, 1);
    chk("R9 acc_wdata byte", s_wd, 32'h0000_0099);
  endtask

  task automatic t_native_wide();
    access(16'hC010, 2'd2, 1, 0, 0);
    chk("R6 tf_sel_s", s_tfs, 8'h01);
    chk("R6 width 32", s_dw, 2);
    chk("R9 rd_data word", s_rd, 32'h5566_7788);
    access(16'hC000, 2'd1, 0, 1, 32'hDEAD_BEEF);
    chk("R6 tf_sel_p", s_tfp, 8'h01);
    chk("R6 width 16", s_dw, 1);
    chk("R9 acc_wdata half", s_wd, 32'h0000_BEEF);
  endtask

  task automatic t_misaligned();
    access(16'hC002, 2'd1, 1, 0, 0);
    chk("R7 no select", {s_tfp, s_tfs}, 0);
    chk("R7 rd_valid", s_rv, 1);
    chk("R7 ones 16", s_rd, 32'h0000_FFFF);
    access(16'hC004, 2'd2, 0, 1, 32'h1111_2222);
    chk("R7 write dropped", {s_tfp, s_wr}, 0);
    chk("R7 wdata kept", s_wd, 32'h0000_BEEF);
  endtask

  task automatic t_ctl();
    access(16'hC00A, 2'd0, 1, 0, 0);
    chk("R8 alt status sel", {s_cp, s_wr}, 2'b10);
    chk("R8 alt status data", s_rd, 32'h0000_00D4);
    access(16'hC01A, 2'd0, 0, 1, 32'h0000_0006);
    chk("R8 devctl sel", {s_cs, s_wr}, 2'b11);
    access(16'hC008, 2'd0, 1, 0, 0);
    chk("R8 bad offset no sel", s_cp, 0);
    chk("R8 bad offset ones", s_rd, 32'h0000_00FF);
    access(16'hC00A, 2'd2, 1, 0, 0);
    chk("R8 wide ones", s_rd, 32'hFFFF_FFFF);
    chk("R8 wide no sel", s_cp, 0);
    access(16'hC009, 2'd0, 0, 1, 32'h0000_0004);
    chk("R8 write ignored", {s_cp, s_wr}, 0);
  endtask

  task automatic t_legacy();
    set_pif(8'h8A);
    chk("R2 int_pin legacy", int_pin, 0);
    chk("R2 legacy_mode", legacy_mode, 1);
    access(16'h01F7, 2'd0, 1, 0, 0);
    chk("R3 primary cmd", s_tfp, 8'h80);
    chk("R3 primary data", s_rd, 32'h0000_00D4);
    access(16'h03F6, 2'd0, 1, 0, 0);
    chk("R3 primary ctl", s_cp, 1);
    access(16'h0376, 2'd0, 0, 1, 32'h2);
    chk("R3 secondary ctl", s_cs, 1);
    access(16'h0170, 2'd1, 1, 0, 0);
    chk("R3 secondary cmd", {s_tfs, 6'd0, s_dw}, {8'h01, 6'd0, 2'd1});
    chk("R3 secondary data", s_rd, 32'h0000_7788);
    access(16'hC003, 2'd0, 1, 0, 0);
    chk("R3 native off", {s_tfp, s_rv}, 0);
  endtask

  task automatic t_nibbles();
    set_pif(8'h0B);
    chk("R2 nibble B keeps", {legacy_mode, int_pin}, {1'b1, 8'd0});
    set_pif(8'hA0);
    chk("R2 high nibble A keeps", legacy_mode, 1);
    set_pif(8'h8F);
    chk("R2 int_pin native", {legacy_mode, int_pin}, {1'b0, 8'd1});
    access(16'h01F0, 2'd0, 1, 0, 0);
    chk("R4 legacy off", {s_tfp, s_rv}, 0);
  endtask

  task automatic t_ignore();
    access(16'hC000, 2'd0, 1, 1, 32'h55);
    chk("R10 both strobes", {s_tfp, s_rv, s_wr}, 0);
    access(16'hC000, 2'd3, 1, 0, 0);
    chk("R10 size 3", {s_tfp, s_rv}, 0);
    access(16'h0100, 2'd0, 1, 0, 0);
    chk("R10 outside", {s_rv, s_tfp, s_tfs}, 0);
    chk("R9 idle bus", s_rd, 0);
  endtask

  task automatic t_overlap();
    nat_cmd_base_s = 16'hC000;
    access(16'hC001, 2'd0, 1, 0, 0);
    chk("R11 primary wins", s_tfp, 8'h02);
    chk("R11 secondary quiet", s_tfs, 0);
    chk("R11 primary data", s_rd, 32'h0000_00D4);
    nat_cmd_base_s = 16'hC010;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pif_we = 1'b0; pif_val = 8'h00;
    nat_cmd_base_p = 16'hC000; nat_ctl_base_p = 16'hC008;
    nat_cmd_base_s = 16'hC010; nat_ctl_base_s = 16'hC018;
    io_addr = '0; io_size = '0; io_rd = 1'b0; io_wr = 1'b0; io_wdata = '0;
    chan_rdata_p = 32'hA1B2_C3D4; chan_rdata_s = 32'h5566_7788;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_native_byte();
    t_native_wide();
    t_misaligned();
    t_ctl();
    t_legacy();
    t_nibbles();
    t_ignore();
    t_overlap();
    if (!done) begin
      done = 1;
      summary();
      $finish;
    end
  end

endmodule